// File: doc/BRIEF.md
# Steerable Interrupt Routing Controller

The block gathers sixteen level-sensitive device interrupt sources, arranged in three groups (seven PCI, six local, three ISA), and drives three processor interrupt lines. Each source owns a 2-bit steering field that picks the line it reaches, or disconnects it. A processor line is raised while at least one source steered to it is both pending and enabled. A fourth, keyboard register gives the keyboard source an extra enable. Software sets and reads all of this through a plain 32-bit register port with a single write strobe and a combinational read path.

A separate group of five fatal-event sources (I/O parity error, ISA NMI, bus error, power failure, debug switch) cannot be steered. Each one is captured on its rising edge into a sticky status bit. Any set status bit raises a dedicated fatal line. Software clears the status by writing ones, so writing back the word it has just read clears exactly the events it saw.

All source inputs pass through a two-flop synchronizer before the block uses them. Register reads are decoded by word offset on a 4-bit address.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, every enable bit, steering field and fatal status bit is zero, `cpu_irq` and `panic_irq` are low, and every register offset reads zero while all sources are low.
- R2: Writing a group register sets that group's enable bits. Reading it returns the synchronized raw source levels, with or without enables. Offset 0 is local (bit 0 keyboard, bit 1 serial A, bit 2 serial B, bit 3 floppy, bit 4 parallel, bit 5 real-time clock). Offset 2 is PCI (bits 0-3 slot lines, bit 4 Ethernet, bit 5 SCSI, bit 6 USB). Offset 3 is ISA (bit 0 bridge, bit 1 IDE primary, bit 2 IDE secondary).
- R3: Steering field values 0, 1 and 2 route a source to `cpu_irq` bit 0, 1 and 2. The fields sit in the registers at offsets 8-12. Offset 8 holds PCI slot lines 0-3 in bits [1:0], [3:2], [5:4], [7:6]. Offset 9 holds Ethernet, SCSI and USB in [1:0], [3:2], [5:4]. Offset 10 holds local bits 0-3 in [1:0] to [7:6]. Offset 11 holds local bits 4-5 in [1:0] and [3:2]. Offset 12 holds the ISA bits 0-2 in [1:0], [3:2], [5:4].
- R4: A steering field value of 3 disconnects its source from every processor line.
- R5: `cpu_irq[n]` is high exactly while some source that is synchronized-pending and enabled has steering value n.
- R6: A rising edge on a `panic_src` bit sets the matching status bit at offset 1 (same bit order as the port) three clocks later. The bit stays set after the input falls, and `panic_irq` is high while any status bit is set. Fatal events never affect `cpu_irq`.
- R7: Writing offset 1 clears the status bits at the positions where the data holds a one and leaves the others. A rising edge in the same cycle wins over a clear.
- R8: Offset 4 reads the raw keyboard level in bit 0. Writing it sets a second keyboard enable in bit 0, and the keyboard source counts as enabled if either this bit or local enable bit 0 is set.
- R9: Offsets 5-7 and 13-15 read zero, and writes to them change no state.
- R10: A change on a steerable source input becomes visible at `cpu_irq` and in reads after two rising clock edges.
- R11: A steering register reads back the fields it holds; its bits that hold no field read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pci_src | input | 7 | PCI group source levels |
| loc_src | input | 6 | Local group source levels |
| isa_src | input | 3 | ISA group source levels |
| panic_src | input | 5 | Fatal event inputs, edge captured |
| cpu_irq | output | 3 | Steerable processor interrupt lines |
| panic_irq | output | 1 | Dedicated fatal event line |

## Verification
A corrupted steering field or enable bit shows up on `cpu_irq` as a wrong line or a missing line. This appears on the first clock after a pending source meets it, and the same fault shows in the register readback at once. A lost or stuck fatal status bit shows on `panic_irq` and at offset 1 within three clocks of the input edge, or right after the clearing write. The reference model follows every register and synchronizer stage, so any difference in latency shows on the next compared clock.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
// Shared constants and layout functions for the interrupt router.
// Assumes a 4-bit word-offset address and one 2-bit steering field per source.
package irq_router_pkg;
    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int FW      = 2;
    localparam int N_PCI   = 7;
    localparam int N_LOC   = 6;
    localparam int N_ISA   = 3;
    localparam int N_PANIC = 5;
    localparam int N_LINE  = 3;
    localparam int N_STEER = 5;
    localparam int N_SRC   = N_PCI + N_LOC + N_ISA;
    localparam int PCI_BASE = 0;
    localparam int LOC_BASE = PCI_BASE + N_PCI;
    localparam int ISA_BASE = LOC_BASE + N_LOC;
    localparam int KBD_BIT  = 0;
    localparam int SLOT_W   = 4;

    localparam int OFS_LOC    = 0;
    localparam int OFS_PANIC  = 1;
    localparam int OFS_PCI    = 2;
    localparam int OFS_ISA    = 3;
    localparam int OFS_KBD    = 4;
    localparam int OFS_STEER0 = 8;

    // Index of the steering register that holds source s.
    function automatic int steer_reg(input int s);
        if (s < PCI_BASE + SLOT_W)      return 0;
        else if (s < LOC_BASE)          return 1;
        else if (s < LOC_BASE + SLOT_W) return 2;
        else if (s < ISA_BASE)          return 3;
        else                            return 4;
    endfunction

    // Field number (0..3) of source s inside its steering register.
    function automatic int steer_field(input int s);
        if (s < PCI_BASE + SLOT_W)      return s - PCI_BASE;
        else if (s < LOC_BASE)          return s - PCI_BASE - SLOT_W;
        else if (s < LOC_BASE + SLOT_W) return s - LOC_BASE;
        else if (s < ISA_BASE)          return s - LOC_BASE - SLOT_W;
        else                            return s - ISA_BASE;
    endfunction

    // True for offsets that decode to a register.
    function automatic logic addr_defined(input logic [AW-1:0] a);
        return (int'(a) <= OFS_KBD) ||
               (int'(a) >= OFS_STEER0 && int'(a) < OFS_STEER0 + N_STEER);
    endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for W independent level signals.
// Assumes each input holds at least one clock so that it is seen.
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
// Register file: group enables, keyboard enable, per-source steering fields,
// fatal status capture with write-one-to-clear, and the read mux.
// Assumes synchronized inputs; reads are combinational on bus_addr.
module irq_regs
    import irq_router_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [N_SRC-1:0]    src_lvl,
    input  logic [N_PANIC-1:0]  panic_lvl,
    output logic [N_SRC-1:0]    src_en,
    output logic [N_SRC*FW-1:0] steer_flat,
    output logic [N_PANIC-1:0]  panic_stat,
    output logic [N_PANIC-1:0]  panic_rise
);
    logic [N_PCI-1:0]   pci_en_q;
    logic [N_LOC-1:0]   loc_en_q;
    logic [N_ISA-1:0]   isa_en_q;
    logic               kbd_en_q;
    logic [N_PANIC-1:0] panic_prev_q;
    logic [N_PANIC-1:0] panic_clr;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:8];

    // Group enable registers and the extra keyboard enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_en_q <= '0;
            loc_en_q <= '0;
            isa_en_q <= '0;
            kbd_en_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == AW'(OFS_PCI)) pci_en_q <= bus_wdata[N_PCI-1:0];
            if (bus_addr == AW'(OFS_LOC)) loc_en_q <= bus_wdata[N_LOC-1:0];
            if (bus_addr == AW'(OFS_ISA)) isa_en_q <= bus_wdata[N_ISA-1:0];
            if (bus_addr == AW'(OFS_KBD)) kbd_en_q <= bus_wdata[0];
        end
    end

    // One steering field per source, written from its register slot.
    for (genvar s = 0; s < N_SRC; s++) begin : g_fld
        localparam int REG_OFS = OFS_STEER0 + steer_reg(s);
        localparam int BIT_POS = FW * steer_field(s);
        logic [FW-1:0] fld_q;

        // Field register for this source.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_q <= '0;
            else if (bus_wr && bus_addr == AW'(REG_OFS))
                fld_q <= bus_wdata[BIT_POS +: FW];
        end
        assign steer_flat[s*FW +: FW] = fld_q;
    end

    // Per-source enable vector; the keyboard has two enables.
    always_comb begin
        src_en = '0;
        src_en[PCI_BASE +: N_PCI] = pci_en_q;
        src_en[LOC_BASE +: N_LOC] = loc_en_q;
        src_en[LOC_BASE + KBD_BIT] = loc_en_q[KBD_BIT] | kbd_en_q;
        src_en[ISA_BASE +: N_ISA] = isa_en_q;
    end

    // Rising-edge detect and clear mask for the fatal group.
    assign panic_rise = panic_lvl & ~panic_prev_q;
    assign panic_clr  = (bus_wr && bus_addr == AW'(OFS_PANIC)) ?
                        bus_wdata[N_PANIC-1:0] : '0;

    // Sticky fatal status; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            panic_prev_q <= '0;
            panic_stat   <= '0;
        end else begin
            panic_prev_q <= panic_lvl;
            panic_stat   <= (panic_stat & ~panic_clr) | panic_rise;
        end
    end

    // Read mux: raw levels, fatal status and steering readback.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_LOC):   bus_rdata[N_LOC-1:0]   = src_lvl[LOC_BASE +: N_LOC];
            AW'(OFS_PANIC): bus_rdata[N_PANIC-1:0] = panic_stat;
            AW'(OFS_PCI):   bus_rdata[N_PCI-1:0]   = src_lvl[PCI_BASE +: N_PCI];
            AW'(OFS_ISA):   bus_rdata[N_ISA-1:0]   = src_lvl[ISA_BASE +: N_ISA];
            AW'(OFS_KBD):   bus_rdata[0]           = src_lvl[LOC_BASE + KBD_BIT];
            default:        bus_rdata = '0;
        endcase
        for (int s = 0; s < N_SRC; s++) begin
            if (bus_addr == AW'(OFS_STEER0 + steer_reg(s)))
                bus_rdata[FW*steer_field(s) +: FW] = steer_flat[s*FW +: FW];
        end
    end
endmodule

// File: rtl/irq_xbar.sv
`timescale 1ns/1ps
// Crossbar from sources to processor lines.
// A line is the OR of pending, enabled sources whose field names it;
// field values at or above N_LINE reach no line.
module irq_xbar
    import irq_router_pkg::*;
(
    input  logic [N_SRC-1:0]    pend,
    input  logic [N_SRC-1:0]    en,
    input  logic [N_SRC*FW-1:0] steer_flat,
    output logic [N_LINE-1:0]   line
);
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        logic [N_SRC-1:0] hit;
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign hit[s] = pend[s] & en[s] & (steer_flat[s*FW +: FW] == FW'(l));
        end
        assign line[l] = |hit;
    end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
// Top of the steerable interrupt router: synchronizers, register file and
// crossbar. Assumes all inputs are in, or synchronized to, the clk domain
// except the sources, which are synchronized here.
module irq_router
    import irq_router_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [N_PCI-1:0]    pci_src,
    input  logic [N_LOC-1:0]    loc_src,
    input  logic [N_ISA-1:0]    isa_src,
    input  logic [N_PANIC-1:0]  panic_src,
    output logic [N_LINE-1:0]   cpu_irq,
    output logic                panic_irq
);
    logic [N_SRC-1:0]    src_lvl;
    logic [N_PANIC-1:0]  panic_lvl;
    logic [N_SRC-1:0]    src_en;
    logic [N_SRC*FW-1:0] steer_flat;
    logic [N_PANIC-1:0]  panic_stat;
    logic [N_PANIC-1:0]  panic_rise;

    irq_sync #(.W(N_SRC)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .d({isa_src, loc_src, pci_src}), .q(src_lvl)
    );

    irq_sync #(.W(N_PANIC)) u_panic_sync (
        .clk(clk), .rst_n(rst_n), .d(panic_src), .q(panic_lvl)
    );

    irq_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_lvl(src_lvl), .panic_lvl(panic_lvl),
        .src_en(src_en), .steer_flat(steer_flat),
        .panic_stat(panic_stat), .panic_rise(panic_rise)
    );

    irq_xbar u_xbar (
        .pend(src_lvl), .en(src_en), .steer_flat(steer_flat), .line(cpu_irq)
    );

    // Dedicated fatal line follows any set status bit.
    assign panic_irq = |panic_stat;
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
// Property checker for irq_router, attached with bind.
// Observes ports and the internal enable and fatal status nets.
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_wr,
    input logic [DW-1:0]       bus_wdata,
    input logic [DW-1:0]       bus_rdata,
    input logic [N_LINE-1:0]   cpu_irq,
    input logic                panic_irq,
    input logic [N_SRC-1:0]    src_en,
    input logic [N_PANIC-1:0]  panic_stat,
    input logic [N_PANIC-1:0]  panic_rise
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_irq == '0 && !panic_irq));

    // R2
    pci_enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_PCI)) |=>
        (src_en[PCI_BASE +: N_PCI] == $past(bus_wdata[N_PCI-1:0])));

    // R5
    line_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> (src_en != '0));

    // R6
    panic_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == AW'(OFS_PANIC)) |=>
        ((panic_stat & $past(panic_stat)) == $past(panic_stat)));

    // R6
    panic_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (panic_rise != '0) |=> panic_irq);

    // R7
    panic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_PANIC) && panic_rise == '0) |=>
        ((panic_stat & $past(bus_wdata[N_PANIC-1:0])) == '0));

    // R9
    undefined_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_defined(bus_addr) |-> (bus_rdata == '0));
endmodule

bind irq_router irq_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
    .panic_irq(panic_irq), .src_en(src_en), .panic_stat(panic_stat),
    .panic_rise(panic_rise)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
// Bench for irq_router: behavioural reference model updated on each rising
// edge, outputs compared on every falling edge, plus directed register checks.
module irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  pci_in = '0;
    logic [5:0]  loc_in = '0;
    logic [2:0]  isa_in = '0;
    logic [4:0]  panic_in = '0;
    logic [2:0]  cpu_irq;
    logic        panic_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pci_src(pci_in),
        .loc_src(loc_in), .isa_src(isa_in), .panic_src(panic_in),
        .cpu_irq(cpu_irq), .panic_irq(panic_irq)
    );

    // Reference model state
    bit [15:0] m_s1, m_s2, m_en;
    bit        m_kbd;
    int        m_steer [16];
    bit [4:0]  m_pan, m_p1, m_p2, m_p3;

    function automatic int b_reg(input int s);
        case (s)
            0, 1, 2, 3:  return 8;
            4, 5, 6:     return 9;
            7, 8, 9, 10: return 10;
            11, 12:      return 11;
            default:     return 12;
        endcase
    endfunction

    function automatic int b_field(input int s);
        case (s)
            0, 1, 2, 3:  return s;
            4, 5, 6:     return s - 4;
            7, 8, 9, 10: return s - 7;
            11, 12:      return s - 11;
            default:     return s - 13;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] r = 0;
        case (a)
            0: for (int i = 0; i < 6; i++) r[i] = m_s2[7+i];
            1: r[4:0] = m_pan;
            2: r[6:0] = m_s2[6:0];
            3: r[2:0] = m_s2[15:13];
            4: r[0] = m_s2[7];
            default: r = 0;
        endcase
        for (int s = 0; s < 16; s++)
            if (b_reg(s) == a) r = r | (32'(m_steer[s]) << (2 * b_field(s)));
        return r;
    endfunction

    function automatic logic [2:0] m_lines();
        logic [2:0] e = 0;
        for (int s = 0; s < 16; s++)
            if (m_s2[s] && (m_en[s] || (s == 7 && m_kbd)) && m_steer[s] < 3)
                e[m_steer[s]] = 1'b1;
        return e;
    endfunction

    // Model update at each rising edge (inputs change only at falling edges).
    always @(posedge clk) begin
        bit [4:0] clr;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_en = 0; m_kbd = 0;
            m_pan = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
            for (int s = 0; s < 16; s++) m_steer[s] = 0;
        end else begin
            clr = (bus_wr && bus_addr == 4'd1) ? bus_wdata[4:0] : 5'd0;
            m_pan = (m_pan & ~clr) | (m_p2 & ~m_p3);
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = panic_in;
            m_s2 = m_s1; m_s1 = {isa_in, loc_in, pci_in};
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: for (int i = 0; i < 6; i++) m_en[7+i] = bus_wdata[i];
                    2: for (int i = 0; i < 7; i++) m_en[i] = bus_wdata[i];
                    3: for (int i = 0; i < 3; i++) m_en[13+i] = bus_wdata[i];
                    4: m_kbd = bus_wdata[0];
                    default: ;
                endcase
                for (int s = 0; s < 16; s++)
                    if (b_reg(s) == int'(bus_addr))
                        m_steer[s] = int'((bus_wdata >> (2 * b_field(s))) & 32'h3);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every-clock comparison of the interrupt outputs.
    always @(negedge clk) begin
        if (!done) begin
            chk("R5 cpu_irq", {29'd0, cpu_irq}, {29'd0, m_lines()});
            chk("R6 panic_irq", {31'd0, panic_irq}, {31'd0, (m_pan != 0)});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a[3:0];
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;

        // R1: every offset reads zero after reset
        for (int a = 0; a < 16; a++) rd(a, 32'd0, "R1 reset read");
        chk("R1 lines after reset", {29'd0, cpu_irq}, 32'd0);

        // R2: raw pending visible without enables
        @(negedge clk);
        pci_in = 7'h55; loc_in = 6'h2a; isa_in = 3'b101;
        tick(3);
        rd(2, 32'h55, "R2 pci raw");
        rd(0, 32'h2a, "R2 local raw");
        rd(3, 32'h5, "R2 isa raw");
        chk("R2 no enable no line", {29'd0, cpu_irq}, 32'd0);
        wr(3, 32'h7);
        rd(3, 32'h5, "R2 read ignores enable");

        // R3: normal routing, ISA->0, PCI->1, local->2
        wr(8, 32'h55); wr(9, 32'h15);
        wr(10, 32'hAA); wr(11, 32'h0A);
        wr(12, 32'h00);
        wr(2, 32'h7f);
        chk("R3 isa and pci lines", {29'd0, cpu_irq}, 32'h3);
        wr(0, 32'h3f);
        chk("R3 all three lines", {29'd0, cpu_irq}, 32'h7);

        // R11: readback and unowned bits
        rd(8, 32'h55, "R11 steer readback");
        wr(11, 32'hFFFF_FFFF);
        rd(11, 32'h0F, "R11 unowned bits zero");
        wr(11, 32'h0A);

        // R4: disconnect all ISA, then only IDE secondary
        wr(12, 32'h3F);
        chk("R4 isa disconnected", {29'd0, cpu_irq}, 32'h6);
        wr(12, 32'h30);
        chk("R3 bridge back on line 0", {29'd0, cpu_irq}, 32'h7);

        // R10: two-edge latency
        @(negedge clk);
        pci_in = 0; loc_in = 0; isa_in = 0;
        tick(3);
        chk("R10 quiet", {29'd0, cpu_irq}, 32'd0);
        isa_in = 3'b001;
        tick(1);
        chk("R10 one edge", {29'd0, cpu_irq}, 32'd0);
        tick(1);
        chk("R10 two edges", {29'd0, cpu_irq}, 32'd1);

        // R8: keyboard second enable
        isa_in = 0;
        wr(0, 32'h0);
        @(negedge clk);
        loc_in = 6'h01;
        tick(3);
        rd(4, 32'h1, "R8 kbd raw");
        chk("R8 kbd disabled", {31'd0, cpu_irq[2]}, 32'd0);
        wr(4, 32'h1);
        chk("R8 kbd via second enable", {31'd0, cpu_irq[2]}, 32'd1);
        rd(0, 32'h1, "R2 local raw kbd");
        wr(4, 32'h0);
        @(negedge clk);
        loc_in = 0;
        tick(3);

        // R6: edge capture and hold
        panic_in = 5'b00100;
        tick(2);
        chk("R6 before capture", {31'd0, panic_irq}, 32'd0);
        tick(1);
        chk("R6 captured", {31'd0, panic_irq}, 32'd1);
        panic_in = 0;
        tick(3);
        chk("R6 held", {31'd0, panic_irq}, 32'd1);
        rd(1, 32'h4, "R6 status");
        chk("R6 no cpu line", {29'd0, cpu_irq}, 32'd0);

        // R7: write-one-to-clear
        @(negedge clk);
        panic_in = 5'b00001;
        tick(1);
        panic_in = 0;
        tick(4);
        rd(1, 32'h5, "R7 two events");
        wr(1, 32'h4);
        rd(1, 32'h1, "R7 cleared one");
        wr(1, 32'h0);
        rd(1, 32'h1, "R7 zero write keeps");
        chk("R7 line still up", {31'd0, panic_irq}, 32'd1);
        wr(1, 32'h1);
        rd(1, 32'h0, "R7 all clear");
        chk("R7 line down", {31'd0, panic_irq}, 32'd0);

        // R9: undefined offsets
        for (int a = 5; a < 8; a++) wr(a, 32'hFFFF_FFFF);
        for (int a = 13; a < 16; a++) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) rd(a, m_read(a), "R9 map unchanged");
        rd(6, 32'd0, "R9 undefined reads zero");
        rd(14, 32'd0, "R9 undefined reads zero");

        // Random traffic against the model (R2, R5, R6, R7, R11)
        for (int i = 0; i < 800; i++) begin
            logic [31:0] rnd;
            @(negedge clk);
            rnd = $urandom;
            if (rnd[2:0] == 0) pci_in = rnd[14:8];
            if (rnd[5:3] == 0) loc_in = rnd[21:16];
            if (rnd[7:6] == 0) isa_in = rnd[26:24];
            if (rnd[31:28] == 0) panic_in = rnd[31:27];
            else if (rnd[31:28] == 1) panic_in = 0;
            rnd = $urandom;
            bus_wr = (rnd[1:0] == 0);
            bus_addr = rnd[7:4];
            bus_wdata = $urandom;
            #1;
            chk("R2 random read", bus_rdata, m_read(int'(bus_addr)));
        end
        @(negedge clk);
        bus_wr = 1'b0;
        tick(2);
        finish_run();
    end
endmodule